// File: doc/BRIEF.md
# GPIO Port Configuration Register File

This block holds the configuration of one 32-pin general-purpose I/O port and turns it into per-pin pad controls. Software reaches it through a simple 32-bit register interface: a write strobe, an address and write data, with read data returned combinationally from the address. Four configuration bit-vectors (interrupt-select, GPIO-select, the high pattern bit and the low pattern bit) and one pull-enable vector are held. Each of them has a plain view that is replaced on a write, an alias that sets the bits written as 1, and an alias that clears the bits written as 1.

The roles are decided in a fixed order for each pin. If the interrupt-select bit is set, the pin is an interrupt input and the two pattern bits mean trigger settings, which this block does not decode. If it is clear, the GPIO-select bit decides between GPIO and alternate function. A GPIO pin is an input when the high pattern bit is 1 and an output when it is 0. An output drives the low pattern bit. An alternate-function pin selects device function {high, low}.

Pin levels pass through a two-flop synchroniser and can be read at offset 0x00.

Top module: `gpio_cfg_port`

## Requirements
- R1: After reset every pin is a GPIO input: interrupt-select reads 0, GPIO-select reads all ones, the high pattern reads all ones, the low pattern reads 0, and pull_en, pin_oe and pin_alt are all 0.
- R2: A write to a plain view replaces the whole register, and a read of the same offset returns it. The offsets are 0x10 for interrupt-select, 0x20 for GPIO-select, 0x30 for the high pattern, 0x40 for the low pattern and 0x80 for pull-enable.
- R3: A write to plain offset + 4 sets exactly the bits written as 1. A write to plain offset + 8 clears exactly the bits written as 1. All other bits keep their values.
- R4: Reading a set or clear alias, or any unmapped offset, returns 0. A write to offset 0x00 or to an unmapped offset changes no register.
- R5: A pin with interrupt-select 0 and GPIO-select 0 has pin_alt = 1 and pin_oe = 0. Its 2-bit slice pin_func[2i+1:2i] equals {high pattern, low pattern}.
- R6: A pin with interrupt-select 0, GPIO-select 1 and high pattern 0 has pin_oe = 1, and pin_out equals its low pattern bit.
- R7: A pin with interrupt-select 0, GPIO-select 1 and high pattern 1 has pin_oe = 0, pin_out = 0 and pin_alt = 0.
- R8: A pin with interrupt-select 1 has pin_oe, pin_out, pin_alt and its pin_func slice all at 0, whatever its other bits are.
- R9: Offset 0x00 returns pin_in as sampled two rising clock edges earlier, and not one edge earlier.
- R10: pull_en equals the pull-enable register, where a 1 enables the pull. For a pin that is not an alternate function, its pin_func slice is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (8) | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| pin_in | input | NPINS (32) | Asynchronous pad levels |
| pin_oe | output | NPINS (32) | Output enable per pin |
| pin_out | output | NPINS (32) | Driven value per pin |
| pin_alt | output | NPINS (32) | Pin is assigned to a device function |
| pin_func | output | 2*NPINS (64) | Device function number, two bits per pin |
| pull_en | output | NPINS (32) | Pull enable per pin |

## Verification
The role decode is tried with four register patterns. An all-alternate port with the four pattern combinations on pins 0 to 3 shows whether the function number keeps its bit order. A mixed input/output port shows whether the high pattern bit gates the output enable. Interrupt-select set over pins that were outputs and then had GPIO-select cleared shows that the top of the hierarchy overrides both lower bits. Alias writes are made with masks that overlap the set bits only in part, so a wrong OR/AND or a write that lands on the plain view gives a different readback. The level register is sampled one edge and two edges after an input change, which separates a one-flop synchroniser from a two-flop one.

// File: rtl/gpio_cfg_port.sv
`timescale 1ns/1ps
module gpio_cfg_port #(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NPINS-1:0]   pin_oe,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pin_alt,
  output logic [2*NPINS-1:0] pin_func,
  output logic [NPINS-1:0]   pull_en
);

  localparam logic [3:0] G_LVL  = 4'h0;
  localparam logic [3:0] G_INT  = 4'h1;
  localparam logic [3:0] G_SEL  = 4'h2;
  localparam logic [3:0] G_PHI  = 4'h3;
  localparam logic [3:0] G_PLO  = 4'h4;
  localparam logic [3:0] G_PULL = 4'h8;
  localparam logic [1:0] OP_WR  = 2'd0;
  localparam logic [1:0] OP_SET = 2'd1;
  localparam logic [1:0] OP_CLR = 2'd2;

  logic [NPINS-1:0] int_q, sel_q, phi_q, plo_q, pull_q;
  logic [NPINS-1:0] sync1_q, sync2_q;

  logic             in_page, aligned, wr_ok;
  logic [3:0]       grp;
  logic [1:0]       op;
  logic [NPINS-1:0] wd;

  assign in_page = ({{(32-AW){1'b0}}, addr} >> 8) == 32'd0;
  assign aligned = addr[1:0] == 2'b00;
  assign grp     = addr[7:4];
  assign op      = addr[3:2];
  assign wd      = wdata[NPINS-1:0];
  assign wr_ok   = wr_en && in_page && aligned && op != 2'd3;

  function automatic logic [NPINS-1:0] apply(input logic [NPINS-1:0] cur,
                                             input logic [1:0] o,
                                             input logic [NPINS-1:0] d);
    case (o)
      OP_WR:   apply = d;
      OP_SET:  apply = cur | d;
      OP_CLR:  apply = cur & ~d;
      default: apply = cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= '0;
      sel_q  <= '1;
      phi_q  <= '1;
      plo_q  <= '0;
      pull_q <= '0;
    end else if (wr_ok) begin
      case (grp)
        G_INT:   int_q  <= apply(int_q,  op, wd);
        G_SEL:   sel_q  <= apply(sel_q,  op, wd);
        G_PHI:   phi_q  <= apply(phi_q,  op, wd);
        G_PLO:   plo_q  <= apply(plo_q,  op, wd);
        G_PULL:  pull_q <= apply(pull_q, op, wd);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  logic [NPINS-1:0] rsel;
  always_comb begin
    rsel = '0;
    if (in_page && aligned && op == OP_WR) begin
      case (grp)
        G_LVL:   rsel = sync2_q;
        G_INT:   rsel = int_q;
        G_SEL:   rsel = sel_q;
        G_PHI:   rsel = phi_q;
        G_PLO:   rsel = plo_q;
        G_PULL:  rsel = pull_q;
        default: rsel = '0;
      endcase
    end
  end
  assign rdata = 32'(rsel);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic is_alt, is_out;
    assign is_alt  = !int_q[i] && !sel_q[i];
    assign is_out  = !int_q[i] &&  sel_q[i] && !phi_q[i];
    assign pin_alt[i]        = is_alt;
    assign pin_oe[i]         = is_out;
    assign pin_out[i]        = is_out && plo_q[i];
    assign pin_func[2*i +: 2] = is_alt ? {phi_q[i], plo_q[i]} : 2'b00;
  end

  assign pull_en = pull_q;

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe | pin_alt | pin_out) & int_q) == '0); // R8
  AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0); // R6
  AST_SET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && grp == G_SEL && op == OP_SET) |=> sel_q == ($past(sel_q) | $past(wd))); // R3
  AST_CLR_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && grp == G_PULL && op == OP_CLR) |=> (pull_en & $past(wd)) == '0); // R3
  AST_BASE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && grp == G_PLO && op == OP_WR) |=> plo_q == $past(wd)); // R2
  AST_LVL_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && grp == G_LVL) |=> $stable(int_q) && $stable(pull_q)); // R4

endmodule

// File: tb/gpio_cfg_port_tb.sv
`timescale 1ns/1ps
module gpio_cfg_port_tb;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata, pin_in = 0;
  logic [31:0] pin_oe, pin_out, pin_alt, pull_en;
  logic [63:0] pin_func;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  gpio_cfg_port u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_out(pin_out), .pin_alt(pin_alt), .pin_func(pin_func), .pull_en(pull_en));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 oe", pin_oe, 0); check("R1 alt", pin_alt, 0); check("R1 pull", pull_en, 0);
    rd(8'h10, d); check("R1 int", d, 0);
    rd(8'h20, d); check("R1 sel", d, 32'hFFFF_FFFF);
    rd(8'h30, d); check("R1 phi", d, 32'hFFFF_FFFF);
    rd(8'h40, d); check("R1 plo", d, 0);
  endtask

  task automatic t_alt;
    logic [31:0] d;
    wr(8'h30, 32'h0000_000C); wr(8'h40, 32'h0000_000A); wr(8'h20, 32'h0);
    rd(8'h30, d); check("R2 phi readback", d, 32'h0000_000C);
    check("R5 alt", pin_alt, 32'hFFFF_FFFF);
    check("R5 oe", pin_oe, 0);
    check("R5 func", pin_func, 64'h0000_0000_0000_00E4);
  endtask

  task automatic t_gpio_out;
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h30, 32'h0); wr(8'h40, 32'h5A5A_0F0F);
    check("R6 oe", pin_oe, 32'hFFFF_FFFF);
    check("R6 out", pin_out, 32'h5A5A_0F0F);
    check("R10 func idle", pin_func, 0);
  endtask

  task automatic t_gpio_in;
    wr(8'h30, 32'hFFFF_0000);
    check("R7 oe", pin_oe, 32'h0000_FFFF);
    check("R7 out", pin_out, 32'h0000_0F0F);
    check("R7 alt", pin_alt, 0);
  endtask

  task automatic t_irq;
    wr(8'h14, 32'h0000_00FF);
    check("R8 oe", pin_oe, 32'h0000_FF00);
    check("R8 out", pin_out, 32'h0000_0F00);
    wr(8'h28, 32'h0000_00FF);
    check("R8 alt", pin_alt, 0);
    check("R8 func", pin_func, 0);
    wr(8'h18, 32'h0000_000F);
    check("R5 irq cleared alt", pin_alt, 32'h0000_000F);
  endtask

  task automatic t_alias;
    logic [31:0] d;
    wr(8'h80, 32'h0000_F00F);
    check("R10 pull", pull_en, 32'h0000_F00F);
    wr(8'h84, 32'h0000_0F00);
    rd(8'h80, d); check("R3 set", d, 32'h0000_FF0F);
    wr(8'h88, 32'h0000_000F);
    rd(8'h80, d); check("R3 clr", d, 32'h0000_FF00);
    check("R10 pull after", pull_en, 32'h0000_FF00);
    rd(8'h84, d); check("R4 set alias reads 0", d, 0);
    rd(8'h88, d); check("R4 clr alias reads 0", d, 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R4 lvl not writable", d, 0);
    wr(8'h90, 32'hFFFF_FFFF);
    rd(8'h90, d); check("R4 unmapped reads 0", d, 0);
    wr(8'h8C, 32'hFFFF_FFFF);
    rd(8'h80, d); check("R4 pull untouched", d, 32'h0000_FF00);
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h10, d); check("R4 int untouched", d, 32'h0000_00F0);
  endtask

  task automatic t_sync;
    logic [31:0] d;
    @(negedge clk); pin_in = 32'hDEAD_BEEF; addr = 8'h00;
    @(negedge clk); rd(8'h00, d); check("R9 one edge", d, 0);
    @(negedge clk); rd(8'h00, d); check("R9 two edges", d, 32'hDEAD_BEEF);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_alt();
    t_gpio_out();
    t_gpio_in();
    t_irq();
    t_alias();
    t_unmapped();
    t_sync();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule